// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle and Break Frames

This block turns parallel data words into a single non-return-to-zero serial line. Each bit period is set by a baud divider that belongs to the transmitter alone. A word enters through a valid/ready handshake. A word-length select picks 8 or 9 data bits. Each word goes out with a low start bit, its data bits lowest first, and a high stop bit. Between frames the line stays high.

Two special frames can also be requested. An idle frame holds the line high for one full frame length and has no start bit. A break frame holds the line low for one full frame length and is then followed by one extra high bit period, so that a receiver can find the next start edge. The block shows `busy` while a frame is on the line. It pulses `tx_done` for one cycle when a frame has finished.

Top module: `async_tx_brk`

## Requirements
- R1: After reset, `line_out` is 1, `busy` is 0, `tx_done` is 0 and `in_ready` is 1 when no special request is raised.
- R2: A data frame is one low start bit, then the data bits with bit 0 first, then one high stop bit.
- R3: With `word9`=1 the frame carries 9 data bits, `in_data[8]` last, and lasts 11 bit periods. With `word9`=0 it carries `in_data[7:0]`, ignores `in_data[8]`, and lasts 10 bit periods.
- R4: An idle frame holds `line_out` high for 10 bit periods (`word9`=0) or 11 bit periods (`word9`=1), with `busy` high for the whole frame.
- R5: A break frame holds `line_out` low for 10 or 11 bit periods, matching `word9`, and then high for one extra bit period before the frame ends.
- R6: Each bit period lasts `divisor` clock cycles. A `divisor` of 0 or 1 gives one cycle per bit.
- R7: While `busy` is high, `in_ready` is 0 and all requests are ignored. The frame on the line is not changed by them.
- R8: When several requests are raised together, break is served first, then idle, then data. `in_ready` is 0 while `break_req` or `idle_req` is raised.
- R9: `tx_done` is high for exactly one cycle. That cycle comes right after the last bit period of a frame, with `busy` already low.
- R10: `divisor` is captured when a frame is accepted. Changing it during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 16 | Clock cycles per bit period |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| in_data | input | 9 | Data word to send |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Data word can be taken this cycle |
| idle_req | input | 1 | Request an idle frame |
| break_req | input | 1 | Request a break frame |
| line_out | output | 1 | Serial output line |
| busy | output | 1 | A frame is being sent |
| tx_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions check on every cycle that `tx_done` is a single-cycle pulse following the end of `busy`, and that an accepted word starts with a low line. They also check that an accepted break drives the line low, that the line holds steady inside a bit period, and that the shift state moves only on bit boundaries. Other behaviour can only be shown by the bench's scenarios, because it needs whole frames compared against expected bit patterns. This covers bit order, frame length in both word modes, the extra high bit after a break, the effective divisor including 0 and 1, request priority, and the immunity of a running frame to new requests and divisor changes.

// File: rtl/async_tx_brk.sv
module async_tx_brk #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             word9,
  input  logic [8:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             idle_req,
  input  logic             break_req,
  output logic             line_out,
  output logic             busy,
  output logic             tx_done
);
  localparam int FW = 12;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0]    shreg;
  logic [LW-1:0]    left;
  logic [DIV_W-1:0] cnt, div_q, div_m1;
  logic             do_brk, do_idl, do_dat, start, tick;
  logic [LW-1:0]    base_len;
  logic [FW-1:0]    frame;
  logic [LW-1:0]    frame_len;

  assign do_brk   = break_req & ~busy;
  assign do_idl   = idle_req & ~break_req & ~busy;
  assign in_ready = ~busy & ~break_req & ~idle_req;
  assign do_dat   = in_valid & in_ready;
  assign start    = do_brk | do_idl | do_dat;
  assign base_len = word9 ? LW'(11) : LW'(10);
  assign div_m1   = (div_q == '0) ? '0 : div_q - 1'b1;
  assign tick     = (cnt == div_m1);
  assign line_out = ~busy | shreg[0];

  always_comb begin
    if (do_brk) begin
      frame     = FW'(1) << base_len;           // R5 extra high bit
      frame_len = base_len + 1'b1;
    end else if (do_idl) begin
      frame     = '1;                           // R4
      frame_len = base_len;
    end else if (word9) begin
      frame     = {2'b11, in_data, 1'b0};       // R3
      frame_len = base_len;
    end else begin
      frame     = {3'b111, in_data[7:0], 1'b0}; // R2
      frame_len = base_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tx_done <= 1'b0;
      shreg   <= '1;
      left    <= '0;
      cnt     <= '0;
      div_q   <= '0;
    end else begin
      tx_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          shreg <= frame;
          left  <= frame_len;
          cnt   <= '0;
          div_q <= divisor;
        end
      end else if (tick) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        left  <= left - 1'b1;
        if (left == LW'(1)) begin
          busy    <= 1'b0;
          tx_done <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);                                      // R9
  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!busy && $past(busy)));                        // R9
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    do_dat |=> (busy && !line_out));                            // R2
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    do_brk |=> (busy && !line_out));                            // R5
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cnt != '0) |-> $stable(line_out));  // R6
  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(shreg));  // R7
endmodule

// File: tb/async_tx_brk_bench.sv
module async_tx_brk_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic word9 = 1'b0, in_valid = 1'b0, idle_req = 1'b0, break_req = 1'b0;
  logic [8:0] in_data = '0;
  logic in_ready, line_out, busy, tx_done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  async_tx_brk u_async_tx_brk (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .word9(word9),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .idle_req(idle_req), .break_req(break_req), .line_out(line_out),
    .busy(busy), .tx_done(tx_done));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 data, 1 idle, 2 break
  function automatic int exp_kind(input logic brk, input logic idl);
    return brk ? 2 : (idl ? 1 : 0);
  endfunction

  function automatic int exp_len(input int kind, input logic w9);
    return (w9 ? 11 : 10) + (kind == 2 ? 1 : 0);
  endfunction

  function automatic logic exp_bit(input int kind, input logic w9, input logic [8:0] d, input int i);
    int nd = w9 ? 9 : 8;
    if (kind == 1) return 1'b1;
    if (kind == 2) return (i == nd + 2);
    if (i == 0) return 1'b0;
    if (i <= nd) return d[i-1];
    return 1'b1;
  endfunction

  task automatic run_frame(input logic brk, input logic idl, input logic vld,
                           input logic w9, input logic [8:0] d, input int dv,
                           input bit disturb, input string req);
    int kind = exp_kind(brk, idl);
    int de = (dv == 0) ? 1 : dv;
    int n = exp_len(kind, w9);
    int bad_line = 0, bad_busy = 0;
    break_req = brk; idle_req = idl; in_valid = vld; word9 = w9;
    in_data = d; divisor = 16'(dv);
    #1;
    check({req, " R8 in_ready"}, 32'(in_ready), 32'(!brk && !idl));
    @(posedge clk); @(negedge clk);
    break_req = 0; idle_req = 0; in_valid = 0;
    for (int k = 1; k <= n * de; k++) begin
      if (k > 1) @(negedge clk);
      if (disturb && k == 2) begin
        break_req = 1; idle_req = 1; in_valid = 1; divisor = 16'd9;
        in_data = ~d; word9 = ~w9;
        #1;
        check({req, " R7 ready while busy"}, 32'(in_ready), 32'd0);
      end
      if (disturb && k == 3) begin
        break_req = 0; idle_req = 0; in_valid = 0; divisor = 16'(dv);
      end
      if (line_out !== exp_bit(kind, w9, d, (k - 1) / de)) bad_line++;
      if (busy !== 1'b1) bad_busy++;
    end
    check({req, " R2 R3 R4 R5 R6 line pattern mismatches"}, 32'(bad_line), 32'd0);
    check({req, " R4 busy mismatches"}, 32'(bad_busy), 32'd0);
    @(negedge clk);
    check({req, " R9 done/busy"}, {30'd0, tx_done, busy}, 32'b10);
    check({req, " R1 line rests high"}, 32'(line_out), 32'd1);
    @(negedge clk);
    check({req, " R9 done one cycle"}, 32'(tx_done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    check("R1 line after reset", 32'(line_out), 32'd1);
    check("R1 busy after reset", 32'(busy), 32'd0);
    check("R1 done after reset", 32'(tx_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(in_ready), 32'd1);
    run_frame(0, 0, 1, 0, 9'h1A5, 3, 0, "R2 8-bit data, R3 bit8 ignored");
    run_frame(0, 0, 1, 1, 9'h155, 2, 0, "R3 9-bit data");
    run_frame(0, 1, 0, 0, 9'h000, 2, 0, "R4 idle 8-bit");
    run_frame(0, 1, 0, 1, 9'h000, 1, 0, "R4 idle 9-bit");
    run_frame(1, 0, 0, 0, 9'h000, 2, 0, "R5 break 8-bit");
    run_frame(1, 0, 0, 1, 9'h000, 3, 0, "R5 break 9-bit");
    run_frame(0, 0, 1, 0, 9'h0C3, 0, 0, "R6 divisor zero");
    run_frame(0, 0, 1, 1, 9'h0FF, 1, 0, "R6 divisor one");
    run_frame(1, 1, 1, 0, 9'h0F0, 2, 0, "R8 all raised, break wins");
    run_frame(0, 1, 1, 1, 9'h0F0, 1, 0, "R8 idle over data");
    run_frame(0, 0, 1, 0, 9'h03C, 4, 1, "R7 R10 disturbed frame");
    for (int i = 0; i < 40; i++) begin
      logic [2:0] r = 3'($urandom_range(0, 7));
      run_frame(r == 0, r == 1, 1'b1, 1'($urandom_range(0, 1)),
                9'($urandom), $urandom_range(0, 5), ($urandom_range(0, 3) == 0),
                "random frame");
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule